// File: doc/BRIEF.md
# Repeated-Address Command Sequence Detector

This block watches a CPU memory bus and picks out a deliberately unusual run of cycles: a number of back-to-back accesses that all land on one fixed address, immediately followed by a refresh cycle. While the refresh cycle is on the bus, its address carries the CPU's interrupt-vector and refresh registers. The block latches that address as a 16-bit command word. The upper byte is the operation code and the lower byte is a parameter. The command then applies to exactly one following data access. On that access the block drives the cartridge flash output enable for a read command or the flash write enable for a write command. This lets software read or program flash from code that runs anywhere.

The fixed address is compared only under a mask, so the pattern can hit at several locations. Match history is kept in a short chain of one-bit stages instead of a stored previous address. A small state machine moves through three states. `ST_SEEK` waits for the chain to fill. `ST_PRIMED` means the chain is full and the next refresh cycle will be captured. `ST_ARMED` means a command is held for the next data access. The transitions are:
- fill: from SEEK to PRIMED, on the hit that completes the chain.
- capture: from PRIMED to ARMED, on a refresh cycle.
- miss: from PRIMED to SEEK, on a non-matching access.
- hold: PRIMED stays PRIMED on a further hit.
- consume: from ARMED to SEEK, on the next non-refresh access.

Every bus cycle is shown to the block as a one-clock strobe `cyc_vld`, with `cyc_rfsh` and `cyc_wr` qualifying it.

Top module: `seq_cmd_detect`

## Requirements
- R1: After reset: `cmd_valid`, `flash_oe` and `flash_we` are low, `cmd_word` is 0, and any match progress is discarded.
- R2: A non-refresh access hits when `(cyc_addr & MATCH_MASK) == (MATCH_ADDR & MATCH_MASK)`. The defaults are MATCH_ADDR=16'h3FF0 and MATCH_MASK=16'hFFF0, so bits 3:0 are ignored.
- R3: After HITS (default 3) consecutive hitting non-refresh accesses, the next cycle that is a refresh cycle loads its address into `cmd_word`. `cmd_valid` is high from the following clock.
- R4: A non-hitting non-refresh access before capture discards all progress, so HITS new hits are needed.
- R5: A refresh cycle before the chain is full neither advances nor clears the progress.
- R6: Further hits while primed keep the block primed, so a later refresh still captures.
- R7: While armed, refresh cycles are ignored. `cmd_word` and `cmd_valid` are unchanged by them. The first non-refresh access consumes the command, and `cmd_valid` is low from the next clock.
- R8: Bit 15 of the command (bit 7 of the upper byte) selects the direction: 1 means write, 0 means read. During the consuming access, when it lies in the ROM window (address bits 15:14 both 0), a read command with a read access (`cyc_wr`=0) drives `flash_oe` high. A write command with a write access drives `flash_we` high. Both strobes are combinational in that cycle.
- R9: A consuming access outside the ROM window, or one whose direction differs from the command, drives neither strobe but still consumes the command.
- R10: `flash_oe` and `flash_we` are never high together, and neither is high for any access that is not a consuming one.
- R11: `cmd_word` holds its value until the next capture, including after the command is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | One-clock strobe marking a bus memory cycle |
| cyc_rfsh | input | 1 | Qualifies the strobed cycle as a refresh cycle |
| cyc_wr | input | 1 | Qualifies the strobed cycle as a write (0 = read) |
| cyc_addr | input | 16 | Bus address of the strobed cycle |
| cmd_word | output | 16 | Last captured command (upper byte op, lower byte parameter) |
| cmd_valid | output | 1 | A command is armed for the next data access |
| flash_oe | output | 1 | Flash output enable, active high |
| flash_we | output | 1 | Flash write enable, active high |

## Verification
The detector is driven with several patterns:
- A clean run of hits on different masked-equal addresses, followed by a refresh. This shows that the ignored low bits really are ignored.
- A run broken by a miss. This separates the chain-clearing behaviour from simple counting.
- Refreshes sprinkled inside a partial run. These show that refreshes leave the progress untouched.
- An over-long run of hits. This shows that the primed state holds.
- A pattern that differs from the match address in a compared bit (16'h3FE0). This shows that the mask is not wider than specified.

For each consuming access, the test varies the command direction against the access direction and the ROM window. This separates the output-enable path, the write-enable path and the blocked cases.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;

    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_PRIMED = 2'd1,
        ST_ARMED  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/seq_addr_match.sv
module seq_addr_match #(
    parameter int          AW         = 16,
    parameter logic [15:0] MATCH_ADDR = 16'h3FF0,
    parameter logic [15:0] MATCH_MASK = 16'hFFF0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic          rom_win
);
    localparam logic [AW-1:0] MASK_W  = AW'(MATCH_MASK);
    localparam logic [AW-1:0] MATCH_W = AW'(MATCH_ADDR) & MASK_W;

    always_comb begin
        hit     = ((addr & MASK_W) == MATCH_W);
        rom_win = (addr[AW-1:AW-2] == 2'b00);
    end
endmodule

// File: rtl/seq_hit_chain.sv
module seq_hit_chain #(
    parameter int HITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic hit,
    input  logic clr,
    output logic full,
    output logic will_fill
);
    // HITS must be at least 2
    logic [HITS-1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage[0] <= 1'b0;
        end else if (clr || (step && !hit)) begin
            stage[0] <= 1'b0;
        end else if (step) begin
            stage[0] <= 1'b1;
        end
    end

    for (genvar i = 1; i < HITS; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[i] <= 1'b0;
            end else if (clr || (step && !hit)) begin
                stage[i] <= 1'b0;
            end else if (step) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    always_comb begin
        full      = &stage;
        will_fill = step && hit && (&stage[HITS-2:0]);
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       rfsh_cyc,
    input  logic       hit,
    input  logic       will_fill,
    input  logic       cmd_wr_sel,
    input  logic       acc_wr,
    input  logic       rom_win,
    output seq_state_t state,
    output logic       capture,
    output logic       consume,
    output logic       flash_oe,
    output logic       flash_we
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SEEK:   if (will_fill) nxt = ST_PRIMED;
            ST_PRIMED: begin
                if (rfsh_cyc)          nxt = ST_ARMED;
                else if (acc && !hit)  nxt = ST_SEEK;
            end
            ST_ARMED:  if (acc) nxt = ST_SEEK;
            default:   nxt = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEEK;
        else        state <= nxt;
    end

    always_comb begin
        capture  = 1'b0;
        consume  = 1'b0;
        flash_oe = 1'b0;
        flash_we = 1'b0;
        unique case (state)
            ST_SEEK:   ;
            ST_PRIMED: capture = rfsh_cyc;
            ST_ARMED: begin
                consume  = acc;
                flash_oe = acc && rom_win && !acc_wr && !cmd_wr_sel;
                flash_we = acc && rom_win &&  acc_wr &&  cmd_wr_sel;
            end
            default:   ;
        endcase
    end

    assert_oe_we_excl_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_oe && flash_we));

    assert_consume_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (flash_oe || flash_we) |=> (state == ST_SEEK));

    assert_armed_rfsh_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && rfsh_cyc && !acc) |=> (state == ST_ARMED));
endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
    import seq_cmd_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          HITS       = 3,
    parameter logic [15:0] MATCH_ADDR = 16'h3FF0,
    parameter logic [15:0] MATCH_MASK = 16'hFFF0,
    parameter int          WR_BIT     = AW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_vld,
    input  logic          cyc_rfsh,
    input  logic          cyc_wr,
    input  logic [AW-1:0] cyc_addr,
    output logic [AW-1:0] cmd_word,
    output logic          cmd_valid,
    output logic          flash_oe,
    output logic          flash_we
);
    logic       acc, rfsh_cyc, hit, rom_win;
    logic       step, clr, full, will_fill;
    logic       capture, consume;
    seq_state_t state;
    logic [AW-1:0] cmd_q;

    always_comb begin
        acc      = cyc_vld && !cyc_rfsh;
        rfsh_cyc = cyc_vld &&  cyc_rfsh;
        step     = acc && (state != ST_ARMED);
        clr      = capture || consume;
    end

    seq_addr_match #(
        .AW(AW), .MATCH_ADDR(MATCH_ADDR), .MATCH_MASK(MATCH_MASK)
    ) u_match (
        .addr(cyc_addr), .hit(hit), .rom_win(rom_win)
    );

    seq_hit_chain #(.HITS(HITS)) u_chain (
        .clk(clk), .rst_n(rst_n), .step(step), .hit(hit), .clr(clr),
        .full(full), .will_fill(will_fill)
    );

    seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .acc(acc), .rfsh_cyc(rfsh_cyc),
        .hit(hit), .will_fill(will_fill), .cmd_wr_sel(cmd_q[WR_BIT]),
        .acc_wr(cyc_wr), .rom_win(rom_win), .state(state),
        .capture(capture), .consume(consume),
        .flash_oe(flash_oe), .flash_we(flash_we)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmd_q <= '0;
        else if (capture) cmd_q <= cyc_addr;
    end

    always_comb begin
        cmd_word  = cmd_q;
        cmd_valid = (state == ST_ARMED);
    end

    assert_capture_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (full && rfsh_cyc) |=> (cmd_valid && cmd_word == $past(cyc_addr)));

    assert_stable_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        !(full && rfsh_cyc) |=> $stable(cmd_word));

    assert_primed_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMED) == full);

    assert_miss_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !hit && state != ST_ARMED) |=> (state == ST_SEEK && !full));

    assert_rfsh_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK && rfsh_cyc) |=> (state == ST_SEEK));
endmodule

// File: tb/tb_seq_cmd_detect.sv
module tb_seq_cmd_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_vld = 1'b0, cyc_rfsh = 1'b0, cyc_wr = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic [15:0] cmd_word;
    logic        cmd_valid, flash_oe, flash_we;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic seen_oe, seen_we;

    always #2 clk = ~clk;

    seq_cmd_detect dut (
        .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_rfsh(cyc_rfsh),
        .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cmd_word(cmd_word),
        .cmd_valid(cmd_valid), .flash_oe(flash_oe), .flash_we(flash_we)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; strobes sampled mid-cycle, registered outputs valid on return
    task automatic bus(input logic [15:0] a, input logic rf, input logic wr);
        @(negedge clk);
        cyc_vld = 1'b1; cyc_rfsh = rf; cyc_wr = wr; cyc_addr = a;
        #1;
        seen_oe = flash_oe;
        seen_we = flash_we;
        @(posedge clk);
        #1;
        cyc_vld = 1'b0; cyc_rfsh = 1'b0; cyc_wr = 1'b0;
    endtask

    task automatic hits(input int n);
        for (int i = 0; i < n; i++) bus(16'h3FF0 + 16'(i % 16), 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 cmd_valid", {15'd0, cmd_valid}, 16'd0);
        chk("R1 cmd_word", cmd_word, 16'h0000);
        chk("R1 strobes", {14'd0, flash_oe, flash_we}, 16'd0);
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_read;
        hits(3);
        bus(16'h1234, 1'b1, 1'b0);
        chk("R3 capture valid", {15'd0, cmd_valid}, 16'd1);
        chk("R3 capture word", cmd_word, 16'h1234);
        bus(16'h0100, 1'b0, 1'b0);
        chk("R8 read oe", {15'd0, seen_oe}, 16'd1);
        chk("R10 read no we", {15'd0, seen_we}, 16'd0);
        chk("R7 consumed", {15'd0, cmd_valid}, 16'd0);
        chk("R11 word held", cmd_word, 16'h1234);
    endtask

    task automatic t_write;
        hits(3);
        bus(16'h8A55, 1'b1, 1'b0);
        chk("R3 write cmd", cmd_word, 16'h8A55);
        bus(16'h2000, 1'b0, 1'b1);
        chk("R8 write we", {15'd0, seen_we}, 16'd1);
        chk("R10 write no oe", {15'd0, seen_oe}, 16'd0);
    endtask

    task automatic t_miss_and_rfsh;
        hits(2);
        bus(16'h0100, 1'b0, 1'b0);
        chk("R10 seek read no oe", {15'd0, seen_oe}, 16'd0);
        hits(1);
        bus(16'h4444, 1'b1, 1'b0);
        chk("R4 no capture after miss", {15'd0, cmd_valid}, 16'd0);
        chk("R11 word unchanged", cmd_word, 16'h8A55);
        hits(2);
        bus(16'h0777, 1'b1, 1'b0);
        chk("R5 capture across refresh", {15'd0, cmd_valid}, 16'd1);
        chk("R5 captured word", cmd_word, 16'h0777);
        bus(16'h0010, 1'b0, 1'b0);
    endtask

    task automatic t_extra_hits;
        hits(5);
        bus(16'h0F0F, 1'b1, 1'b0);
        chk("R6 primed holds", cmd_word, 16'h0F0F);
        bus(16'h5555, 1'b1, 1'b0);
        chk("R7 refresh ignored word", cmd_word, 16'h0F0F);
        chk("R7 refresh ignored valid", {15'd0, cmd_valid}, 16'd1);
        bus(16'h8000, 1'b0, 1'b0);
        chk("R9 outside window no oe", {15'd0, seen_oe}, 16'd0);
        chk("R9 outside consumed", {15'd0, cmd_valid}, 16'd0);
    endtask

    task automatic t_dir_mismatch;
        hits(3);
        bus(16'h0033, 1'b1, 1'b0);
        bus(16'h0200, 1'b0, 1'b1);
        chk("R9 mismatch no strobes", {14'd0, seen_oe, seen_we}, 16'd0);
        chk("R9 mismatch consumed", {15'd0, cmd_valid}, 16'd0);
    endtask

    task automatic t_mask;
        bus(16'h3FF0, 1'b0, 1'b0);
        bus(16'h3FF0, 1'b0, 1'b0);
        bus(16'h3FE0, 1'b0, 1'b0);
        bus(16'h1111, 1'b1, 1'b0);
        chk("R2 compared bit differs", {15'd0, cmd_valid}, 16'd0);
        bus(16'h3FF9, 1'b0, 1'b0);
        bus(16'h3FF3, 1'b0, 1'b0);
        bus(16'h3FFF, 1'b0, 1'b0);
        bus(16'h2222, 1'b1, 1'b0);
        chk("R2 ignored low bits", cmd_word, 16'h2222);
    endtask

    initial begin
        t_reset;
        t_read;
        t_write;
        t_miss_and_rfsh;
        t_extra_hits;
        t_dir_mismatch;
        t_mask;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule